// File: doc/BRIEF.md
# Register-Write Script Interpreter

This block walks a byte-coded script held in a 256-byte buffer and turns it into a stream of 32-bit register writes. It keeps two working registers, an address register and a data register. Load opcodes fill or patch the data register. Address opcodes set the address register and then send the current data register to that address on a valid/ready write port. Because the data register is not cleared between writes, a run of writes that share one value needs only address opcodes.

Besides writes, a script can do three other things. It can stall until a set of display heads all reach a chosen level. It can switch a bus-enable flag off and back on around a critical sequence. It ends with an exit opcode. Any byte that is not a known opcode is stepped over as a no-operation, and its value is kept in a debug output. If a script runs off the end of the buffer without an exit, the block stops and raises its error flag.

A start pulse launches a run from byte 0. The buffer is read combinationally: the block drives a byte index, and the buffer returns that byte in the same cycle.

Top module: `regscript_engine`

## Requirements
- R1: Byte 0xE2 is followed by four operand bytes, lowest byte first, and these bytes replace all 32 bits of the data register.
- R2: Byte 0x42 is followed by two operand bytes, lowest first, that replace data bits 15:0. Data bits 31:16 keep their value.
- R3: Byte 0xE0 is followed by four operand bytes, lowest first, that replace the whole address register. One write of the current data register to the new address follows.
- R4: Byte 0x40 is followed by two operand bytes, lowest first, that replace address bits 15:0 and keep bits 31:16. One write of the current data register follows.
- R5: A write is offered with `wr_valid` high. The block holds `wr_valid`, `wr_addr` and `wr_data` steady, and fetches nothing, until `wr_ready` is high at a clock edge.
- R6: Byte 0x5F takes two operand bytes. The first is a head mask, where bit h selects head h. Bit 0 of the second byte is the level to wait for. Execution stalls until `head_flag[h]` equals that level for every selected head. Heads that are not selected are ignored.
- R7: Byte 0xB0 drives `bus_en` low and byte 0xD0 drives it high. Neither takes an operand.
- R8: Byte 0x7F ends the run. `done` goes high and `busy` goes low.
- R9: Any other byte met in opcode position is a one-byte no-operation. It causes no write, and its value appears on `dbg_byte`.
- R10: If an opcode or operand fetch is due at byte index 256, the run stops with `error` high and `done` low.
- R11: A start pulse while not busy resets the address and data registers to 0xFFFFFFFF, drives `bus_en` high, clears `done` and `error`, and fetches from index 0. `busy` is high in the next cycle.
- R12: After reset the block is idle: `busy`, `done`, `error` and `wr_valid` are low and `bus_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run from byte 0 |
| script_addr | output | 8 | Byte index into the script buffer |
| script_byte | input | 8 | Buffer byte at `script_addr`, same cycle |
| head_flag | input | NUM_HEADS | Per-head condition levels tested by the wait opcode |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write port accepts the request |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| bus_en | output | 1 | Outside bus access allowed |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended on the exit opcode |
| error | output | 1 | Run ran past the end of the buffer |
| dbg_byte | output | 8 | Last no-operation byte consumed |

## Verification
Each script byte costs one cycle. A write therefore appears one cycle after the cycle that reads its last operand byte, and it stays on the port through every cycle that `wr_ready` is low. Because of this, the scoreboard does not predict cycle numbers. A driver task queues each expected write, with the bus-enable level it should see, while it builds the script. The monitor compares at the falling edge only on cycles where valid and ready are both high, so a stall of any length keeps the order intact. Level-type results (`done`, `error`, `dbg_byte`, a blocked wait) are checked after the run has settled, or after a fixed count of idle cycles during a stall, and always sampled at the falling edge.

// File: rtl/regscript_pkg.sv
package regscript_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;

    // Opcode values: the operand length of each is fixed by its value
    localparam logic [BYTE_W-1:0] OPC_DATA_FULL = 8'hE2;
    localparam logic [BYTE_W-1:0] OPC_DATA_LOW  = 8'h42;
    localparam logic [BYTE_W-1:0] OPC_ADDR_FULL = 8'hE0;
    localparam logic [BYTE_W-1:0] OPC_ADDR_LOW  = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_HEAD_WAIT = 8'h5F;
    localparam logic [BYTE_W-1:0] OPC_BUS_OFF   = 8'hB0;
    localparam logic [BYTE_W-1:0] OPC_BUS_ON    = 8'hD0;
    localparam logic [BYTE_W-1:0] OPC_EXIT      = 8'h7F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPND,
        ST_WAIT,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } eng_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    // Number of operand bytes after an opcode (0 = single-byte opcode)
    function automatic logic [2:0] operand_count(input logic [BYTE_W-1:0] op);
        case (op)
            OPC_DATA_FULL, OPC_ADDR_FULL:               return 3'd4;
            OPC_DATA_LOW, OPC_ADDR_LOW, OPC_HEAD_WAIT:  return 3'd2;
            default:                                    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/regscript_operand.sv
module regscript_operand
    import regscript_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [1:0]          idx,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic [WORD_W-1:0]   word
);
    logic [WORD_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (load)
            acc_q[idx*BYTE_W +: BYTE_W] <= byte_in;
    end

    // Merge the byte being read this cycle so the last operand is usable at once
    always_comb begin
        word = acc_q;
        word[idx*BYTE_W +: BYTE_W] = byte_in;
    end
endmodule

// File: rtl/regscript_head_wait.sv
module regscript_head_wait #(
    parameter int NUM_HEADS = 2
) (
    input  logic [NUM_HEADS-1:0] mask,
    input  logic                 level,
    input  logic [NUM_HEADS-1:0] head_flag,
    output logic                 met
);
    logic [NUM_HEADS-1:0] head_ok;

    for (genvar h = 0; h < NUM_HEADS; h++) begin : g_head
        assign head_ok[h] = !mask[h] || (head_flag[h] == level);
    end

    assign met = &head_ok;
endmodule

// File: rtl/regscript_engine.sv
module regscript_engine
    import regscript_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int NUM_HEADS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic [$clog2(DEPTH)-1:0] script_addr,
    input  logic [7:0]               script_byte,
    input  logic [NUM_HEADS-1:0]     head_flag,
    output logic                     wr_valid,
    input  logic                     wr_ready,
    output logic [31:0]              wr_addr,
    output logic [31:0]              wr_data,
    output logic                     bus_en,
    output logic                     busy,
    output logic                     done,
    output logic                     error,
    output logic [7:0]               dbg_byte
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    eng_state_e            st_q;
    logic [PTR_W-1:0]      pc_q;
    logic [BYTE_W-1:0]     op_q;
    logic [1:0]            idx_q;
    wr_req_t               req_q;
    logic                  bus_en_q;
    logic [BYTE_W-1:0]     dbg_q;
    logic [NUM_HEADS-1:0]  wmask_q;
    logic                  wlvl_q;
    logic [WORD_W-1:0]     opnd_word;
    logic                  wait_met;
    logic                  at_end;
    logic                  last_opnd;

    assign at_end    = (pc_q == PTR_W'(DEPTH));
    assign last_opnd = ({1'b0, idx_q} == (operand_count(op_q) - 3'd1));

    regscript_operand u_opnd (
        .clk     (clk),
        .rst     (rst),
        .load    (st_q == ST_OPND && !at_end),
        .idx     (idx_q),
        .byte_in (script_byte),
        .word    (opnd_word)
    );

    regscript_head_wait #(.NUM_HEADS(NUM_HEADS)) u_wait (
        .mask      (wmask_q),
        .level     (wlvl_q),
        .head_flag (head_flag),
        .met       (wait_met)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            pc_q     <= '0;
            op_q     <= '0;
            idx_q    <= '0;
            req_q    <= '1;
            bus_en_q <= 1'b1;
            dbg_q    <= '0;
            wmask_q  <= '0;
            wlvl_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE, ST_DONE, ST_FAULT: begin
                    if (start) begin
                        st_q     <= ST_FETCH;
                        pc_q     <= '0;
                        req_q    <= '1;
                        bus_en_q <= 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (at_end) begin
                        st_q <= ST_FAULT;
                    end else begin
                        pc_q  <= pc_q + 1'b1;
                        op_q  <= script_byte;
                        idx_q <= '0;
                        if (operand_count(script_byte) != 3'd0) begin
                            st_q <= ST_OPND;
                        end else begin
                            case (script_byte)
                                OPC_BUS_OFF: bus_en_q <= 1'b0;
                                OPC_BUS_ON:  bus_en_q <= 1'b1;
                                OPC_EXIT:    st_q     <= ST_DONE;
                                default:     dbg_q    <= script_byte;
                            endcase
                        end
                    end
                end
                ST_OPND: begin
                    if (at_end) begin
                        st_q <= ST_FAULT;
                    end else begin
                        pc_q  <= pc_q + 1'b1;
                        idx_q <= idx_q + 1'b1;
                        if (last_opnd) begin
                            st_q <= ST_FETCH;
                            case (op_q)
                                OPC_DATA_FULL: req_q.data        <= opnd_word;
                                OPC_DATA_LOW:  req_q.data[15:0]  <= opnd_word[15:0];
                                OPC_ADDR_FULL: begin
                                    req_q.addr <= opnd_word;
                                    st_q       <= ST_WRITE;
                                end
                                OPC_ADDR_LOW: begin
                                    req_q.addr[15:0] <= opnd_word[15:0];
                                    st_q             <= ST_WRITE;
                                end
                                OPC_HEAD_WAIT: begin
                                    wmask_q <= opnd_word[NUM_HEADS-1:0];
                                    wlvl_q  <= opnd_word[BYTE_W];
                                    st_q    <= ST_WAIT;
                                end
                                default: ;
                            endcase
                        end
                    end
                end
                ST_WAIT: begin
                    if (wait_met)
                        st_q <= ST_FETCH;
                end
                ST_WRITE: begin
                    if (wr_ready)
                        st_q <= ST_FETCH;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign script_addr = pc_q[IDX_W-1:0];
    assign wr_valid    = (st_q == ST_WRITE);
    assign wr_addr     = req_q.addr;
    assign wr_data     = req_q.data;
    assign bus_en      = bus_en_q;
    assign busy        = (st_q == ST_FETCH) || (st_q == ST_OPND) ||
                         (st_q == ST_WAIT)  || (st_q == ST_WRITE);
    assign done        = (st_q == ST_DONE);
    assign error       = (st_q == ST_FAULT);
    assign dbg_byte    = dbg_q;
endmodule

// File: rtl/regscript_engine_chk.sv
module regscript_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        bus_en,
    input logic        busy,
    input logic        done,
    input logic        error
);
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R3
    wr_in_run_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !wr_valid));

    // R10
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (!done && !busy));

    // R11
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && bus_en && !done && !error));
endmodule

bind regscript_engine regscript_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bus_en   (bus_en),
    .busy     (busy),
    .done     (done),
    .error    (error)
);

// File: tb/regscript_engine_tb.sv
`timescale 1ns/1ps
module regscript_engine_tb;
    localparam int DEPTH = 256;
    localparam int HEADS = 2;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic        bus;
        string       tag;
    } exp_wr_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [7:0]       script_addr;
    logic [7:0]       script_byte;
    logic [HEADS-1:0] head_flag = '0;
    logic             wr_valid;
    logic             wr_ready = 1'b1;
    logic [31:0]      wr_addr, wr_data;
    logic             bus_en, busy, done, error;
    logic [7:0]       dbg_byte;

    logic [7:0]  rom [DEPTH];
    int          wp;
    logic [31:0] m_addr, m_data;
    logic        m_bus;
    exp_wr_t     expq[$];
    int          vectors = 0;
    int          fails = 0;
    int          seen_writes = 0;

    always #2 clk = ~clk;

    assign script_byte = rom[script_addr];

    regscript_engine #(.DEPTH(DEPTH), .NUM_HEADS(HEADS)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .script_addr(script_addr), .script_byte(script_byte),
        .head_flag(head_flag),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_en(bus_en), .busy(busy), .done(done), .error(error),
        .dbg_byte(dbg_byte)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare every accepted write against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && wr_valid && wr_ready) begin
            seen_writes++;
            if (expq.size() == 0) begin
                chk(1'b0, "R3/R4 unexpected write", {wr_addr, wr_data}, 64'h0);
            end else begin
                exp_wr_t e;
                e = expq.pop_front();
                chk(wr_addr == e.addr, {e.tag, " addr"}, {32'h0, wr_addr}, {32'h0, e.addr});
                chk(wr_data == e.data, {e.tag, " data"}, {32'h0, wr_data}, {32'h0, e.data});
                chk(bus_en == e.bus, "R7 bus_en at write", {63'h0, bus_en}, {63'h0, e.bus});
            end
        end
    end

    // Driver tasks: build the script and queue the writes it must produce
    task automatic new_script(input logic [7:0] fill);
        for (int i = 0; i < DEPTH; i++) rom[i] = fill;
        wp = 0; m_addr = '1; m_data = '1; m_bus = 1'b1;
    endtask
    task automatic put(input logic [7:0] b);
        rom[wp] = b; wp++;
    endtask
    task automatic ld_data(input logic [31:0] v);
        put(8'hE2); put(v[7:0]); put(v[15:8]); put(v[23:16]); put(v[31:24]);
        m_data = v;
    endtask
    task automatic ld_data_lo(input logic [15:0] v);
        put(8'h42); put(v[7:0]); put(v[15:8]);
        m_data[15:0] = v;
    endtask
    task automatic wr_full(input logic [31:0] a, input string tag);
        put(8'hE0); put(a[7:0]); put(a[15:8]); put(a[23:16]); put(a[31:24]);
        m_addr = a;
        expq.push_back('{m_addr, m_data, m_bus, tag});
    endtask
    task automatic wr_low(input logic [15:0] a, input string tag);
        put(8'h40); put(a[7:0]); put(a[15:8]);
        m_addr[15:0] = a;
        expq.push_back('{m_addr, m_data, m_bus, tag});
    endtask
    task automatic bus_set(input bit on);
        put(on ? 8'hD0 : 8'hB0); m_bus = on;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask
    task automatic wait_end();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done || error) break;
        end
    endtask
    task automatic check_done(input string tag);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R8 done"}, {63'h0, done}, 64'h1);
        chk(busy == 1'b0, {tag, " R8 busy"}, {63'h0, busy}, 64'h0);
        chk(error == 1'b0, {tag, " R10 no error"}, {63'h0, error}, 64'h0);
        chk(expq.size() == 0, {tag, " writes outstanding"}, 64'(expq.size()), 64'h0);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        new_script(8'h7F);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !error && !wr_valid, "R12 idle flags",
            {60'h0, busy, done, error, wr_valid}, 64'h0);
        chk(bus_en == 1'b1, "R12 bus_en", {63'h0, bus_en}, 64'h1);

        // Script A: full/short loads, writes, bus gating (R1 R2 R3 R4 R7)
        new_script(8'h7F);
        ld_data(32'hA5B6_C7D8);
        wr_full(32'h0010_02D4, "R1/R3");
        ld_data_lo(16'h1234);
        wr_low(16'h02D0, "R2/R4");
        wr_low(16'h0210, "R4 reuse data");
        bus_set(1'b0);
        ld_data(32'h8000_0000);
        wr_full(32'h0000_400C, "R7 bus off");
        bus_set(1'b1);
        ld_data_lo(16'hBEEF);
        wr_low(16'h4008, "R7 bus on");
        put(8'h7F);
        pulse_start();
        wait_end();
        check_done("scriptA");

        // Script B: restart re-initializes registers to all ones (R11), nop capture (R9)
        new_script(8'h7F);
        wr_low(16'h1111, "R11 ones");
        put(8'h0A);
        put(8'h05);
        put(8'h7F);
        pulse_start();
        wait_end();
        check_done("scriptB");
        chk(dbg_byte == 8'h05, "R9 dbg_byte", {56'h0, dbg_byte}, 64'h05);
        chk(seen_writes == 6, "R9 no write from nop", 64'(seen_writes), 64'd6);

        // Script C: write back-pressure (R5)
        new_script(8'h7F);
        ld_data(32'h0C01_0904);
        wr_full(32'h0010_0224, "R5 stalled write");
        put(8'h7F);
        wr_ready = 1'b0;
        pulse_start();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wr_valid) break;
        end
        repeat (5) @(negedge clk);
        chk(wr_valid && busy, "R5 valid held", {62'h0, wr_valid, busy}, 64'h3);
        chk(wr_addr == 32'h0010_0224, "R5 addr held", {32'h0, wr_addr}, 64'h0010_0224);
        chk(expq.size() == 1, "R5 not accepted yet", 64'(expq.size()), 64'd1);
        @(posedge clk); #1 wr_ready = 1'b1;
        wait_end();
        check_done("scriptC");

        // Script D: head waits (R6)
        new_script(8'h7F);
        head_flag = 2'b10;
        ld_data(32'h0000_3300);
        put(8'h5F); put(8'h01); put(8'h01);
        wr_full(32'h0061_1200, "R6 after level-1 wait");
        put(8'h5F); put(8'h03); put(8'h00);
        wr_low(16'h2504, "R6 after level-0 wait");
        put(8'h7F);
        pulse_start();
        repeat (30) @(negedge clk);
        chk(busy && seen_writes == 7, "R6 stalled on head0 low",
            {31'h0, busy, 32'(seen_writes)}, {31'h0, 1'b1, 32'd7});
        @(posedge clk); #1 head_flag = 2'b01;
        repeat (30) @(negedge clk);
        chk(busy && seen_writes == 8, "R6 stalled on head0 high",
            {31'h0, busy, 32'(seen_writes)}, {31'h0, 1'b1, 32'd8});
        @(posedge clk); #1 head_flag = 2'b00;
        wait_end();
        check_done("scriptD");

        // Script E: operand fetch runs past buffer end (R10)
        new_script(8'h00);
        rom[DEPTH-1] = 8'h42;
        pulse_start();
        wait_end();
        @(negedge clk);
        chk(error == 1'b1, "R10 error", {63'h0, error}, 64'h1);
        chk(done == 1'b0 && busy == 1'b0, "R10 stopped", {62'h0, done, busy}, 64'h0);
        chk(seen_writes == 9, "R10 no writes", 64'(seen_writes), 64'd9);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule